// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs a repeating cycle of three phases: auto-zero, signal integrate and reference deintegrate. It drives one enable for each phase and a reference-sign select, which control the analog switches around an external integrator. Every phase is timed in counts, and one count is two clock cycles. The comparator that watches the integrator is an input. The block latches the input polarity when integration ends. During deintegrate it counts until the comparator reports that the integrator has crossed back through zero.

The deintegrate count becomes a four-digit BCD result. The upper digit is limited to 0 to 3, so the result runs from 0 to 3999. A longer count is flagged as overrange, and the underrange flag marks small readings. The total of auto-zero and deintegrate is fixed, so auto-zero absorbs whatever time deintegrate did not use. A range input picks a 2000-count or a 200-count integrate window. A peak input keeps only rising readings, and a hold input freezes the displayed result while conversions keep running. An active-low strobe marks the end of every conversion.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset the block is in auto-zero (az_o=1, int_o=0, deint_o=0) with bcd_o=0, ovr_o=0, unr_o=1 and eoc_no=1. The first auto-zero lasts 6000 counts (12000 clock cycles).
- R2: Exactly one of az_o, int_o, deint_o is high in every cycle. One count is two clock cycles, and every phase length is an exact multiple of two cycles.
- R3: The integrate phase always follows auto-zero. It lasts 2000 counts when range_i was 0 at the clock edge that ended auto-zero, and 200 counts when it was 1.
- R4: Deintegrate follows integrate. It ends at the first count at which cmp_i differs from the value cmp_i had at the last integrate count. If that is count index k (0-based), deintegrate lasts k+1 counts and the result is k. With no crossing, it ends after 4001 counts.
- R5: Auto-zero follows deintegrate, and auto-zero plus deintegrate is always 6000 counts. Auto-zero therefore runs from 1999 to 5999 counts.
- R6: neg_o is the inverse of cmp_i at the last integrate count. ref_neg_o is high only during deintegrate, equals that sampled cmp_i, and stays constant for the whole phase.
- R7: A result above 3999, or a deintegrate that reached 4001 counts with no crossing, sets ovr_o=1. The digits on bcd_o keep their previous value and neg_o is updated. A later in-range result clears ovr_o.
- R8: unr_o is 1 exactly when ovr_o=0 and the displayed result is 380 or less.
- R9: With peak_i=1 at the end of deintegrate, the display changes only if the new result is strictly greater than the one shown, or if the new result is overrange while the display is not. An overrange display stays.
- R10: With hold_i=1 at the end of deintegrate, bcd_o, neg_o and ovr_o do not change, but the conversion cycle keeps its timing.
- R11: eoc_no goes low for exactly one clock cycle after every deintegrate ends. Any new result appears on the display outputs in that same cycle, and they change in no other cycle.
- R12: bcd_o holds the result as packed BCD: bits 15:12 thousands, 11:8 hundreds, 7:4 tens, 3:0 units. Bits 15:12 never exceed 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator: 1 when the integrator is on its positive side |
| range_i | input | 1 | 1 selects the short integrate window |
| peak_i | input | 1 | Peak-reading mode |
| hold_i | input | 1 | Freeze the display |
| az_o | output | 1 | Auto-zero switch enable |
| int_o | output | 1 | Signal-integrate switch enable |
| deint_o | output | 1 | Reference-deintegrate switch enable |
| ref_neg_o | output | 1 | Apply the negative reference during deintegrate |
| bcd_o | output | 16 | Displayed result, packed BCD |
| neg_o | output | 1 | Displayed polarity, 1 = negative |
| ovr_o | output | 1 | Overrange |
| unr_o | output | 1 | Underrange |
| eoc_no | output | 1 | End-of-conversion strobe, active low |

## Verification
The bench places zero crossings at the first deintegrate count, at 380 and 381, at 3999 and 4000, and omits the crossing entirely. A design that is off by one count at any of these would report the wrong digits, set or miss the underrange or overrange flag, or leave a deintegrate and auto-zero pair whose total is not 6000 counts. Peak mode is given both smaller and larger readings, and an overrange reading is followed by an in-range one, to expose an update rule that keeps or replaces the wrong value. Hold, the short integrate window and the polarity latch are each checked against phase lengths counted at the ports and against the output values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  // packs v as nd BCD digits, units in the low nibble
  function automatic logic [31:0] to_bcd(int unsigned v, int unsigned nd);
    logic [31:0]  r;
    int unsigned  t;
    r = '0;
    t = v;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nd)) r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/adc_tick.sv
module adc_tick (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign tick_o = half_q;

endmodule

// File: rtl/adc_bcd_cnt.sv
module adc_bcd_cnt #(
  parameter int N_DIG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  output logic [N_DIG*4-1:0] dig_o
);

  localparam int DW = N_DIG * 4;

  logic [DW-1:0] dig_q;
  logic [N_DIG:0] carry;

  assign carry[0] = inc_i;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    logic at_nine;
    assign at_nine      = (dig_q[g*4 +: 4] == 4'd9);
    assign carry[g + 1] = carry[g] & at_nine;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q[g*4 +: 4] <= 4'd0;
      else if (clr_i)    dig_q[g*4 +: 4] <= 4'd0;
      else if (carry[g]) dig_q[g*4 +: 4] <= at_nine ? 4'd0 : dig_q[g*4 +: 4] + 4'd1;
    end
  end

  assign dig_o = dig_q;

endmodule

// File: rtl/adc_phase_ctl.sv
module adc_phase_ctl
  import adc_seq_pkg::*;
#(
  parameter int INT_LONG  = 2000,
  parameter int INT_SHORT = 200,
  parameter int DEINT_MAX = 4001,
  parameter int AZ_DEINT  = 6000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   range_i,
  input  logic   cmp_i,
  output phase_e phase_o,
  output logic   pos_o,
  output logic   cnt_clr_o,
  output logic   cnt_inc_o,
  output logic   done_o,
  output logic   timeout_o
);

  localparam int INT_MAX = (INT_LONG > INT_SHORT) ? INT_LONG : INT_SHORT;
  localparam int RW = $clog2(AZ_DEINT + 1);
  localparam int IW = $clog2(INT_MAX + 1);

  phase_e        phase_q;
  logic [RW-1:0] rest_q;
  logic [IW-1:0] int_q;
  logic [IW-1:0] int_end;
  logic          rng_q;
  logic          pos_q;
  logic          crossed, int_last, az_last, deint_last;

  assign int_end    = rng_q ? IW'(INT_SHORT - 1) : IW'(INT_LONG - 1);
  assign int_last   = (int_q == int_end);
  assign az_last    = (rest_q == RW'(AZ_DEINT - 1));
  assign deint_last = (rest_q == RW'(DEINT_MAX - 1));
  assign crossed    = (cmp_i != pos_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      rest_q  <= '0;
      int_q   <= '0;
      rng_q   <= 1'b0;
      pos_q   <= 1'b0;
    end else if (tick_i) begin
      case (phase_q)
        PH_AZ: begin
          if (az_last) begin
            phase_q <= PH_INT;
            int_q   <= '0;
            rng_q   <= range_i;
          end else begin
            rest_q <= rest_q + 1'b1;
          end
        end
        PH_INT: begin
          if (int_last) begin
            phase_q <= PH_DEINT;
            pos_q   <= cmp_i;
            rest_q  <= '0;
          end else begin
            int_q <= int_q + 1'b1;
          end
        end
        PH_DEINT: begin
          // one shared count: auto-zero resumes where deintegrate stopped
          rest_q <= rest_q + 1'b1;
          if (crossed || deint_last) phase_q <= PH_AZ;
        end
        default: phase_q <= PH_AZ;
      endcase
    end
  end

  always_comb begin
    cnt_clr_o = tick_i && (phase_q == PH_INT) && int_last;
    cnt_inc_o = tick_i && (phase_q == PH_DEINT) && !crossed;
    done_o    = tick_i && (phase_q == PH_DEINT) && (crossed || deint_last);
    timeout_o = tick_i && (phase_q == PH_DEINT) && !crossed && deint_last;
  end

  assign phase_o = phase_q;
  assign pos_o   = pos_q;

endmodule

// File: rtl/adc_result.sv
module adc_result
  import adc_seq_pkg::*;
#(
  parameter int N_DIG      = 4,
  parameter int FULL_SCALE = 3999,
  parameter int UNDER_LIM  = 380
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic               timeout_i,
  input  logic [N_DIG*4-1:0] cnt_i,
  input  logic               neg_i,
  input  logic               peak_i,
  input  logic               hold_i,
  output logic [N_DIG*4-1:0] bcd_o,
  output logic               neg_o,
  output logic               ovr_o,
  output logic               unr_o,
  output logic               eoc_no
);

  localparam int DW = N_DIG * 4;
  localparam logic [31:0] FS_WIDE = to_bcd(FULL_SCALE, N_DIG);
  localparam logic [31:0] UR_WIDE = to_bcd(UNDER_LIM, N_DIG);
  localparam logic [DW-1:0] FS_BCD = FS_WIDE[DW-1:0];
  localparam logic [DW-1:0] UR_BCD = UR_WIDE[DW-1:0];

  logic [DW-1:0] bcd_q;
  logic          neg_q, ovr_q, eoc_nq;
  logic          new_ovr, larger, take;

  // packed BCD compares like binary digit by digit
  assign new_ovr = timeout_i || (cnt_i > FS_BCD);
  assign larger  = cnt_i > bcd_q;

  always_comb begin
    if (hold_i)      take = 1'b0;
    else if (!peak_i) take = 1'b1;
    else if (ovr_q)  take = 1'b0;
    else             take = new_ovr || larger;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcd_q  <= '0;
      neg_q  <= 1'b0;
      ovr_q  <= 1'b0;
      eoc_nq <= 1'b1;
    end else begin
      eoc_nq <= !done_i;
      if (done_i && take) begin
        neg_q <= neg_i;
        ovr_q <= new_ovr;
        if (!new_ovr) bcd_q <= cnt_i;
      end
    end
  end

  assign bcd_o  = bcd_q;
  assign neg_o  = neg_q;
  assign ovr_o  = ovr_q;
  assign unr_o  = !ovr_q && (bcd_q <= UR_BCD);
  assign eoc_no = eoc_nq;

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import adc_seq_pkg::*;
#(
  parameter int N_DIG      = 4,
  parameter int FULL_SCALE = 3999,
  parameter int UNDER_LIM  = 380,
  parameter int INT_LONG   = 2000,
  parameter int INT_SHORT  = 200,
  parameter int DEINT_MAX  = 4001,
  parameter int AZ_DEINT   = 6000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmp_i,
  input  logic               range_i,
  input  logic               peak_i,
  input  logic               hold_i,
  output logic               az_o,
  output logic               int_o,
  output logic               deint_o,
  output logic               ref_neg_o,
  output logic [N_DIG*4-1:0] bcd_o,
  output logic               neg_o,
  output logic               ovr_o,
  output logic               unr_o,
  output logic               eoc_no
);

  localparam int DW = N_DIG * 4;

  logic          tick;
  phase_e        phase;
  logic          pos, cnt_clr, cnt_inc, done, timeout;
  logic [DW-1:0] cnt;

  adc_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  adc_phase_ctl #(
    .INT_LONG  (INT_LONG),
    .INT_SHORT (INT_SHORT),
    .DEINT_MAX (DEINT_MAX),
    .AZ_DEINT  (AZ_DEINT)
  ) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .range_i   (range_i),
    .cmp_i     (cmp_i),
    .phase_o   (phase),
    .pos_o     (pos),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .done_o    (done),
    .timeout_o (timeout)
  );

  adc_bcd_cnt #(.N_DIG(N_DIG)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .dig_o  (cnt)
  );

  adc_result #(
    .N_DIG      (N_DIG),
    .FULL_SCALE (FULL_SCALE),
    .UNDER_LIM  (UNDER_LIM)
  ) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .timeout_i (timeout),
    .cnt_i     (cnt),
    .neg_i     (!pos),
    .peak_i    (peak_i),
    .hold_i    (hold_i),
    .bcd_o     (bcd_o),
    .neg_o     (neg_o),
    .ovr_o     (ovr_o),
    .unr_o     (unr_o),
    .eoc_no    (eoc_no)
  );

  assign az_o      = (phase == PH_AZ);
  assign int_o     = (phase == PH_INT);
  assign deint_o   = (phase == PH_DEINT);
  assign ref_neg_o = deint_o && pos;

endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int N_DIG = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               peak_i,
  input logic               hold_i,
  input logic               az_o,
  input logic               int_o,
  input logic               deint_o,
  input logic               ref_neg_o,
  input logic [N_DIG*4-1:0] bcd_o,
  input logic               neg_o,
  input logic               ovr_o,
  input logic               eoc_no
);

  localparam int DW = N_DIG * 4;

  p_one_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({az_o, int_o, deint_o}) == 1);

  p_int_after_az_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_o) |-> $past(az_o));

  p_deint_after_int_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deint_o) |-> $past(int_o));

  p_az_after_deint_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(az_o) |-> $past(deint_o));

  p_ref_in_deint_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_neg_o |-> deint_o);

  p_ref_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deint_o && $past(deint_o)) |-> $stable(ref_neg_o));

  p_eoc_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_no |=> eoc_no);

  p_eoc_after_deint_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_no) |-> ($past(deint_o) && az_o));

  p_disp_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_no |-> ($stable(bcd_o) && $stable(neg_o) && $stable(ovr_o)));

  p_hold_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_no && $past(hold_i)) |-> ($stable(bcd_o) && $stable(neg_o) && $stable(ovr_o)));

  p_peak_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_no && $past(peak_i) && !$past(ovr_o)) |-> (bcd_o >= $past(bcd_o)));

  p_peak_ovr_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_no && $past(peak_i) && $past(ovr_o)) |-> ovr_o);

  p_msd_limit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_o[DW-1 -: 4] <= 4'd3);

endmodule

bind dual_slope_seq dual_slope_seq_chk #(.N_DIG(N_DIG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .peak_i    (peak_i),
  .hold_i    (hold_i),
  .az_o      (az_o),
  .int_o     (int_o),
  .deint_o   (deint_o),
  .ref_neg_o (ref_neg_o),
  .bcd_o     (bcd_o),
  .neg_o     (neg_o),
  .ovr_o     (ovr_o),
  .eoc_no    (eoc_no)
);

// File: tb/sim_dual_slope_seq.sv
`timescale 1ns/1ps
module sim_dual_slope_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_i = 1'b0, range_i = 1'b0, peak_i = 1'b0, hold_i = 1'b0;
  logic        az_o, int_o, deint_o, ref_neg_o, neg_o, ovr_o, unr_o, eoc_no;
  logic [15:0] bcd_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int m_val = 0;
  bit m_neg = 0;
  bit m_ovr = 0;
  int az_exp = 12000;

  always #2 clk = ~clk;

  dual_slope_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp_i), .range_i(range_i),
    .peak_i(peak_i), .hold_i(hold_i), .az_o(az_o), .int_o(int_o),
    .deint_o(deint_o), .ref_neg_o(ref_neg_o), .bcd_o(bcd_o), .neg_o(neg_o),
    .ovr_o(ovr_o), .unr_o(unr_o), .eoc_no(eoc_no)
  );

  function automatic logic [15:0] bcd4(int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one conversion; called at a negedge while auto-zero is running
  task automatic conv(bit pos, int k, bit tmo, bit rng, bit pk, bit hd, string tag);
    int m, n, dexp;
    bit nov, upd;
    range_i = rng; peak_i = pk; hold_i = hd; cmp_i = pos;
    m = 0;
    while (az_o) begin m++; @(negedge clk); end
    chk(m == az_exp, "R5 R1 auto-zero clocks", m, az_exp);
    n = 0;
    while (int_o) begin n++; @(negedge clk); end
    chk(n == 2 * (rng ? 200 : 2000), "R2 R3 integrate clocks", n, 2 * (rng ? 200 : 2000));
    chk(deint_o == 1'b1, "R4 deint follows integrate", deint_o, 1);
    chk(ref_neg_o == pos, "R6 reference sign", ref_neg_o, pos);
    n = 0;
    while (deint_o) begin
      if (!tmo && n == 2 * k) cmp_i = ~pos;
      n++;
      @(negedge clk);
    end
    dexp = tmo ? 2 * 4001 : 2 * (k + 1);
    chk(n == dexp, "R2 R4 deintegrate clocks", n, dexp);
    nov = tmo || (k > 3999);
    if (hd)       upd = 0;
    else if (!pk) upd = 1;
    else if (m_ovr) upd = 0;
    else          upd = nov || (k > m_val);
    if (upd) begin
      m_neg = !pos;
      m_ovr = nov;
      if (!nov) m_val = k;
    end
    chk(eoc_no == 1'b0, "R11 eoc low", eoc_no, 0);
    chk(bcd_o == bcd4(m_val), tag, bcd_o, bcd4(m_val));
    chk(neg_o == m_neg, "R6 polarity", neg_o, m_neg);
    chk(ovr_o == m_ovr, "R7 overrange", ovr_o, m_ovr);
    chk(unr_o == (!m_ovr && m_val <= 380), "R8 underrange", unr_o, (!m_ovr && m_val <= 380));
    @(negedge clk);
    chk(eoc_no == 1'b1, "R11 eoc single cycle", eoc_no, 1);
    az_exp = 2 * (6000 - (tmo ? 4001 : k + 1)) - 1;
  endtask

  initial begin
    int rs, rk;
    bit rp;
    rs = $urandom(32'd20251);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(az_o && !int_o && !deint_o, "R1 reset phase", {az_o, int_o, deint_o}, 3'b100);
    chk(bcd_o == 16'h0 && !ovr_o, "R1 reset result", bcd_o, 0);
    chk(unr_o == 1'b1 && eoc_no == 1'b1, "R1 reset flags", {unr_o, eoc_no}, 2'b11);
    conv(1, 1234, 0, 0, 0, 0, "R12 result 1234");
    conv(0, 380,  0, 1, 0, 0, "R8 result 380");
    conv(1, 381,  0, 1, 0, 0, "R8 result 381");
    conv(1, 3999, 0, 0, 0, 0, "R12 full scale 3999");
    conv(0, 4000, 0, 1, 0, 0, "R7 digits kept at 4000");
    conv(1, 0,    0, 1, 0, 0, "R4 immediate crossing");
    conv(1, 0,    1, 1, 0, 0, "R7 no crossing");
    conv(0, 2000, 0, 1, 0, 0, "R7 cleared by in-range");
    conv(1, 1500, 0, 1, 1, 0, "R9 peak keeps larger");
    conv(1, 2500, 0, 1, 1, 0, "R9 peak takes larger");
    rk = int'($urandom_range(3999, 0));
    conv(0, rk,   0, 1, 0, 1, "R10 hold freezes");
    rk = int'($urandom_range(3999, 0));
    rp = bit'($urandom_range(1, 0));
    conv(rp, rk,  0, 1, 0, 0, "R12 random result");
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule